// File: doc/BRIEF.md
# Stack Frame Save/Restore Sequencer

This block executes one compound frame save or frame restore as a series of single 32-bit memory accesses. An already decoded instruction supplies its fields with a one-cycle `start` pulse. These fields are the direction, a short or long encoding, a frame field, an extra-register count, a 4-bit argument code and three flags: keep return address, keep s0 and keep s1. The block then works through a fixed list of register slots. It reads store data from the register file, or writes sign-extended load data into it, and it talks to memory over a request/acknowledge port with only one access outstanding at a time.

A save first writes argument registers into the caller's argument area above the stack pointer, which is register 29. These writes do not move the pointer. The block then pushes the chosen registers at falling addresses and finally lowers register 29 by the frame size. A restore starts its working pointer at register 29 plus the frame size and walks the same push slots in the same order, loading instead of storing. It skips the caller area and then raises register 29 by the frame size. A reserved argument code is reported on `err` and nothing else changes.

The controller has six named states. `ST_IDLE` waits for `start`. `ST_SEEK` picks the next enabled slot, or goes to `ST_SPWB` when no slot is left. `ST_MEM` holds the request until acknowledge and then returns to `ST_SEEK`. `ST_SPWB` writes the new stack pointer and moves to `ST_DONE`. `ST_DONE` raises `done` for one cycle and returns to `ST_IDLE`. `ST_FAULT` is entered from `ST_IDLE` on a reserved code, raises `err` for one cycle and returns to `ST_IDLE`.

Top module: `frame_spill_seq`

## Requirements
- R1: `op_save`=1 selects save: every access has `mem_we`=1. `op_save`=0 selects restore: every access has `mem_we`=0, and each acknowledged load writes the register of its slot.
- R2: A save stores `cn` caller-area arguments without moving the pointer. The slots in write order are reg 7 at SP+12, reg 6 at SP+8, reg 5 at SP+4 and reg 4 at SP+0, and only the last `cn` of them are written. `cn` comes from the argument code: 0–3 and 11 give 0, 4–7 give 1, 8–10 give 2, 12–13 give 3, and 14 gives 4. A restore never touches these slots.
- R3: Push slots pre-decrement a working pointer by 4. Their order is: reg 31 if `keep_ra`; then the last k of the list 30, 23, 22, 21, 20, 19, 18, where k is the extra count; then 17 if `keep_s1`; then 16 if `keep_s0`; then static arguments.
- R4: Static arguments are pushed in the order 7, 6, 5, 4, taking the first `sn` of them. `sn` comes from the argument code: 0, 4, 8, 12 and 14 give 0; 1, 5, 9 and 13 give 1; 2, 6 and 10 give 2; 3 and 7 give 3; 11 gives 4.
- R5: With `long_form`=0, the frame size is 128 when `frame_fld[3:0]` is 0 and `frame_fld[3:0]`×8 otherwise, and the extra count and argument code are treated as 0. With `long_form`=1, the frame size is `frame_fld`×8.
- R6: A save writes SP−frame into register 29. A restore starts its pointer at SP+frame and writes SP+frame into register 29.
- R7: Restore loads are 32-bit words, sign-extended to the register width.
- R8: Argument code 15 in long form raises `err` for one cycle. It issues no memory request and writes no register.
- R9: Only one access is outstanding. `mem_req` and its address and direction hold steady until `mem_ack`, and after reset the block is idle with no request, no register write and no `done` or `err`.
- R10: `done` is high for exactly one cycle, in the cycle right after the stack pointer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that launches an operation |
| op_save | input | 1 | 1 = save, 0 = restore |
| long_form | input | 1 | 1 = extended encoding |
| frame_fld | input | 8 | Frame field (only bits 3:0 are used in short form) |
| extra_cnt | input | 3 | Number of extra saved registers (long form) |
| arg_code | input | 4 | Argument register code (long form) |
| keep_ra | input | 1 | Include register 31 |
| keep_s0 | input | 1 | Include register 16 |
| keep_s1 | input | 1 | Include register 17 |
| rf_rd_idx | output | 5 | Register-file read index |
| rf_rd_data | input | XLEN | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 5 | Register-file write index |
| rf_wr_data | output | XLEN | Register-file write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | XLEN | Byte address |
| mem_wdata | output | 32 | Store data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Load data, valid with acknowledge |
| done | output | 1 | Operation complete |
| err | output | 1 | Reserved argument code |

## Verification
A wrong slot mask or a wrong walk pointer shows up on the very next memory request. The address, the direction or the data bytes no longer match the slot list the bench computes from the tables, so errors in the count tables and in the push order are caught at the first misplaced access. A wrong working pointer or frame size that leaves the access list intact still appears in register 29 once `done` rises. A fault path that leaks shows as a request or a register write in the cycles around `err`.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;
    localparam int SLOT_N  = 18;
    localparam int CALLER_N = 4;
    localparam logic [4:0] SP_IDX = 5'd29;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEEK, ST_MEM, ST_SPWB, ST_DONE, ST_FAULT
    } seq_state_t;

    // Fixed slot list: caller area (0..3), ra (4), extras (5..11),
    // s1 (12), s0 (13), static args (14..17).
    function automatic logic [4:0] slot_reg(input logic [4:0] s);
        case (s)
            5'd0, 5'd14: slot_reg = 5'd7;
            5'd1, 5'd15: slot_reg = 5'd6;
            5'd2, 5'd16: slot_reg = 5'd5;
            5'd3, 5'd17: slot_reg = 5'd4;
            5'd4:        slot_reg = 5'd31;
            5'd5:        slot_reg = 5'd30;
            5'd12:       slot_reg = 5'd17;
            5'd13:       slot_reg = 5'd16;
            default:     slot_reg = 5'd29 - s; // 6..11 -> 23..18
        endcase
    endfunction
endpackage

// File: rtl/argcode_split.sv
module argcode_split (
    input  logic [3:0] code,
    output logic [2:0] caller_n,
    output logic [2:0] static_n,
    output logic       reserved
);
    always_comb begin
        reserved = 1'b0;
        unique case (code)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd11: caller_n = 3'd0;
            4'd4, 4'd5, 4'd6, 4'd7:        caller_n = 3'd1;
            4'd8, 4'd9, 4'd10:             caller_n = 3'd2;
            4'd12, 4'd13:                  caller_n = 3'd3;
            4'd14:                         caller_n = 3'd4;
            default: begin
                caller_n = 3'd0;
                reserved = 1'b1;
            end
        endcase
        unique case (code)
            4'd1, 4'd5, 4'd9, 4'd13: static_n = 3'd1;
            4'd2, 4'd6, 4'd10:       static_n = 3'd2;
            4'd3, 4'd7:              static_n = 3'd3;
            4'd11:                   static_n = 3'd4;
            default:                 static_n = 3'd0;
        endcase
    end
endmodule

// File: rtl/slot_mask_gen.sv
module slot_mask_gen
    import frame_seq_pkg::*;
(
    input  logic              is_save,
    input  logic [2:0]        caller_n,
    input  logic              keep_ra,
    input  logic [2:0]        extra_n,
    input  logic              keep_s1,
    input  logic              keep_s0,
    input  logic [2:0]        static_n,
    output logic [SLOT_N-1:0] mask
);
    localparam int EXTRA_N  = 7;
    localparam int EXTRA_LO = CALLER_N + 1;
    localparam int STAT_LO  = EXTRA_LO + EXTRA_N + 2;

    for (genvar g = 0; g < CALLER_N; g++) begin : g_caller
        localparam logic [2:0] NEED = 3'(CALLER_N - g);
        assign mask[g] = is_save && (caller_n >= NEED);
    end
    assign mask[CALLER_N] = keep_ra;
    for (genvar g = 0; g < EXTRA_N; g++) begin : g_extra
        localparam logic [2:0] NEED = 3'(EXTRA_N - g);
        assign mask[EXTRA_LO + g] = (extra_n >= NEED);
    end
    assign mask[EXTRA_LO + EXTRA_N]     = keep_s1;
    assign mask[EXTRA_LO + EXTRA_N + 1] = keep_s0;
    for (genvar g = 0; g < 4; g++) begin : g_static
        localparam logic [2:0] LIM = 3'(g);
        assign mask[STAT_LO + g] = (static_n > LIM);
    end
endmodule

// File: rtl/frame_spill_seq.sv
module frame_spill_seq
    import frame_seq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            op_save,
    input  logic            long_form,
    input  logic [7:0]      frame_fld,
    input  logic [2:0]      extra_cnt,
    input  logic [3:0]      arg_code,
    input  logic            keep_ra,
    input  logic            keep_s0,
    input  logic            keep_s1,
    output logic [4:0]      rf_rd_idx,
    input  logic [XLEN-1:0] rf_rd_data,
    output logic            rf_we,
    output logic [4:0]      rf_wr_idx,
    output logic [XLEN-1:0] rf_wr_data,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic            mem_ack,
    input  logic [31:0]     mem_rdata,
    output logic            done,
    output logic            err
);
    localparam logic [XLEN-1:0] WORD = XLEN'(4);

    seq_state_t state_q, state_d;
    logic              save_q;
    logic [SLOT_N-1:0] mask_q, mask_w;
    logic [XLEN-1:0]   frame_q, frame_w, sp_q, ptr_q, addr_q;
    logic [4:0]        idx_q, slot_q, nxt_slot;
    logic              nxt_found;
    logic [2:0]        eff_extra, caller_n, static_n;
    logic [3:0]        eff_code;
    logic              code_rsvd;

    // Short form forces extra count and argument code to zero.
    assign eff_extra = long_form ? extra_cnt : 3'd0;
    assign eff_code  = long_form ? arg_code  : 4'd0;
    assign frame_w   = long_form ? XLEN'({frame_fld, 3'b000})
                     : (frame_fld[3:0] == 4'd0) ? XLEN'(128)
                     : XLEN'({frame_fld[3:0], 3'b000});

    argcode_split u_split (
        .code(eff_code), .caller_n(caller_n), .static_n(static_n), .reserved(code_rsvd)
    );

    slot_mask_gen u_mask (
        .is_save(op_save), .caller_n(caller_n), .keep_ra(keep_ra), .extra_n(eff_extra),
        .keep_s1(keep_s1), .keep_s0(keep_s0), .static_n(static_n), .mask(mask_w)
    );

    // Lowest enabled slot at or above the walk index.
    always_comb begin
        nxt_found = 1'b0;
        nxt_slot  = '0;
        for (int k = SLOT_N - 1; k >= 0; k--) begin
            if (mask_q[k] && (5'(k) >= idx_q)) begin
                nxt_found = 1'b1;
                nxt_slot  = 5'(k);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = code_rsvd ? ST_FAULT : ST_SEEK;
            ST_SEEK:  state_d = nxt_found ? ST_MEM : ST_SPWB;
            ST_MEM:   if (mem_ack) state_d = ST_SEEK;
            ST_SPWB:  state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            save_q  <= 1'b0;
            mask_q  <= '0;
            frame_q <= '0;
            sp_q    <= '0;
            ptr_q   <= '0;
            addr_q  <= '0;
            idx_q   <= '0;
            slot_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    save_q  <= op_save;
                    mask_q  <= mask_w;
                    frame_q <= frame_w;
                    sp_q    <= rf_rd_data;
                    ptr_q   <= op_save ? rf_rd_data : rf_rd_data + frame_w;
                    idx_q   <= '0;
                end
                ST_SEEK: if (nxt_found) begin
                    slot_q <= nxt_slot;
                    if (nxt_slot < 5'(CALLER_N)) begin
                        addr_q <= sp_q + XLEN'(12 - 4 * int'(nxt_slot));
                    end else begin
                        addr_q <= ptr_q - WORD;
                        ptr_q  <= ptr_q - WORD;
                    end
                end
                ST_MEM: if (mem_ack) idx_q <= slot_q + 5'd1;
                default: ;
            endcase
        end
    end

    always_comb begin
        rf_rd_idx  = (state_q == ST_IDLE) ? SP_IDX : slot_reg(slot_q);
        mem_req    = (state_q == ST_MEM);
        mem_we     = save_q;
        mem_addr   = addr_q;
        mem_wdata  = rf_rd_data[31:0];
        rf_we      = (state_q == ST_SPWB) || ((state_q == ST_MEM) && mem_ack && !save_q);
        rf_wr_idx  = (state_q == ST_SPWB) ? SP_IDX : slot_reg(slot_q);
        rf_wr_data = (state_q == ST_SPWB) ? (save_q ? sp_q - frame_q : sp_q + frame_q)
                                          : XLEN'($signed(mem_rdata));
        done       = (state_q == ST_DONE);
        err        = (state_q == ST_FAULT);
    end

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_req && !rf_we);
    assert_done_after_sp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rf_we) && ($past(rf_wr_idx) == SP_IDX));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_load_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack && !mem_we |-> rf_we && (rf_wr_idx != SP_IDX));
    assert_caller_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && (slot_q < 5'(CALLER_N)) |-> mem_we && (mem_addr >= sp_q)
                                             && (mem_addr <= sp_q + XLEN'(12)));
endmodule

// File: tb/frame_spill_seq_tb_top.sv
module frame_spill_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_save = 1'b0, long_form = 1'b0;
    logic [7:0]  frame_fld = '0;
    logic [2:0]  extra_cnt = '0;
    logic [3:0]  arg_code = '0;
    logic        keep_ra = 1'b0, keep_s0 = 1'b0, keep_s1 = 1'b0;
    logic [4:0]  rf_rd_idx, rf_wr_idx;
    logic [31:0] rf_rd_data, rf_wr_data, mem_addr, mem_wdata;
    logic        rf_we, mem_req, mem_we, done, err;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    logic [31:0] regs [0:31];
    logic [31:0] mem  [0:1023];
    int checks = 0, errors = 0;
    bit finished = 0;

    int          log_n;
    logic        log_we   [0:63];
    logic [31:0] log_addr [0:63];
    logic [31:0] log_data [0:63];

    int          exp_n;
    logic [31:0] exp_addr [0:31];
    logic [4:0]  exp_reg  [0:31];
    logic [31:0] exp_sp;
    logic [31:0] snap [0:31];

    always #5 clk = ~clk;

    frame_spill_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_save(op_save), .long_form(long_form),
        .frame_fld(frame_fld), .extra_cnt(extra_cnt), .arg_code(arg_code),
        .keep_ra(keep_ra), .keep_s0(keep_s0), .keep_s1(keep_s1),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_we(rf_we),
        .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .err(err)
    );

    assign rf_rd_data = regs[rf_rd_idx];

    initial forever begin
        @(posedge clk);
        if (rf_we && rf_wr_idx != 5'd0) regs[rf_wr_idx] <= rf_wr_data;
    end

    // Memory responder with random acknowledge delay.
    initial begin
        int wait_ctr = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (wait_ctr == 0) begin
                    mem_ack = 1'b1;
                    if (log_n < 64) begin
                        log_we[log_n]   = mem_we;
                        log_addr[log_n] = mem_addr;
                        log_data[log_n] = mem_we ? mem_wdata : mem[mem_addr[11:2]];
                    end
                    log_n++;
                    if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
                    else        mem_rdata = mem[mem_addr[11:2]];
                    wait_ctr = $urandom % 3;
                end else wait_ctr--;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int caller_cnt(input logic [3:0] c);
        if (c == 4'd14) return 4;
        if (c >= 4'd12) return 3;
        if (c == 4'd11) return 0;
        if (c >= 4'd8)  return 2;
        if (c >= 4'd4)  return 1;
        return 0;
    endfunction

    function automatic int static_cnt(input logic [3:0] c);
        if (c == 4'd11) return 4;
        if (c == 4'd14) return 0;
        if (c >= 4'd12) return int'(c) - 12;
        return int'(c) % 4;
    endfunction

    task automatic push_exp(inout logic [31:0] p, input logic [4:0] r);
        p = p - 32'd4;
        exp_addr[exp_n] = p;
        exp_reg[exp_n]  = r;
        exp_n++;
    endtask

    task automatic build_exp(input bit sv, input bit lng, input logic [2:0] xc,
                             input logic [3:0] ac, input bit ra, input bit s0,
                             input bit s1, input logic [7:0] ff);
        logic [4:0]  xlist [0:6];
        logic [31:0] sp, fr, p;
        int k, ac_eff;
        xlist[0] = 30; xlist[1] = 23; xlist[2] = 22; xlist[3] = 21;
        xlist[4] = 20; xlist[5] = 19; xlist[6] = 18;
        k      = lng ? int'(xc) : 0;
        ac_eff = lng ? int'(ac) : 0;
        fr = lng ? {21'd0, ff, 3'd0} : (ff[3:0] == 0 ? 32'd128 : {25'd0, ff[3:0], 3'd0});
        sp = regs[29];
        exp_n = 0;
        if (sv) begin
            for (int j = caller_cnt(4'(ac_eff)) - 1; j >= 0; j--) begin
                exp_addr[exp_n] = sp + 32'(4 * j);
                exp_reg[exp_n]  = 5'(4 + j);
                exp_n++;
            end
        end
        p = sv ? sp : sp + fr;
        if (ra) push_exp(p, 5'd31);
        for (int i = 7 - k; i < 7; i++) push_exp(p, xlist[i]);
        if (s1) push_exp(p, 5'd17);
        if (s0) push_exp(p, 5'd16);
        for (int i = 0; i < static_cnt(4'(ac_eff)); i++) push_exp(p, 5'(7 - i));
        exp_sp = sv ? sp - fr : sp + fr;
    endtask

    task automatic run_op(input bit sv, input bit lng, input logic [2:0] xc,
                          input logic [3:0] ac, input bit ra, input bit s0,
                          input bit s1, input logic [7:0] ff);
        bit rsvd;
        int done_cyc, err_cyc, cyc;
        logic [31:0] expreg [0:31];
        rsvd = lng && (ac == 4'd15);
        build_exp(sv, lng, xc, ac, ra, s0, s1, ff);
        for (int i = 0; i < 32; i++) snap[i] = regs[i];
        log_n = 0;
        @(negedge clk);
        op_save = sv; long_form = lng; extra_cnt = xc; arg_code = ac;
        keep_ra = ra; keep_s0 = s0; keep_s1 = s1; frame_fld = ff; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        done_cyc = 0; err_cyc = 0; cyc = 0;
        while (cyc < 400 && !(done_cyc > 0 && !done) && !(err_cyc > 0 && !err)) begin
            if (done) done_cyc++;
            if (err)  err_cyc++;
            @(negedge clk);
            cyc++;
        end
        if (rsvd) begin
            check(err_cyc == 1 && done_cyc == 0, "R8", "err pulse", 32'(err_cyc), 32'd1);
            check(log_n == 0, "R8", "no memory access", 32'(log_n), 32'd0);
            for (int i = 0; i < 32; i++)
                if (regs[i] !== snap[i]) check(0, "R8", "register unchanged", regs[i], snap[i]);
            checks++;
            return;
        end
        check(done_cyc == 1 && err_cyc == 0, "R10", "done one cycle", 32'(done_cyc), 32'd1);
        check(log_n == exp_n, "R3", "access count", 32'(log_n), 32'(exp_n));
        for (int i = 0; i < 32; i++) expreg[i] = snap[i];
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            check(log_we[i] == sv, "R1", "access direction", 32'(log_we[i]), 32'(sv));
            check(log_addr[i] == exp_addr[i], (sv && exp_addr[i] >= snap[29]) ? "R2" : "R3",
                  "access address", log_addr[i], exp_addr[i]);
            if (sv) check(log_data[i] == snap[exp_reg[i]], "R4", "store data",
                          log_data[i], snap[exp_reg[i]]);
            else expreg[exp_reg[i]] = log_data[i];
        end
        expreg[29] = exp_sp;
        check(regs[29] == exp_sp, "R6", "stack pointer", regs[29], exp_sp);
        for (int i = 0; i < 32; i++)
            if (i != 29 && regs[i] !== expreg[i])
                check(0, "R7", "register file contents", regs[i], expreg[i]);
        checks++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        for (int i = 0; i < 32; i++) regs[i] = (i == 0) ? 32'd0 : $urandom;
        regs[29] = 32'h0000_0800;
        for (int i = 0; i < 1024; i++) mem[i] = $urandom;
        repeat (3) @(negedge clk);
        check(!mem_req && !rf_we && !done && !err, "R9", "reset idle",
              {28'd0, mem_req, rf_we, done, err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Directed corners
        run_op(1, 1, 3'd7, 4'd14, 1, 1, 1, 8'd40);   // R2 four caller args, R3 full push
        run_op(0, 1, 3'd7, 4'd14, 1, 1, 1, 8'd40);   // R1 R7 restore, caller area skipped
        run_op(1, 1, 3'd2, 4'd11, 0, 1, 0, 8'd20);   // R4 four static args
        run_op(0, 1, 3'd2, 4'd11, 0, 1, 0, 8'd20);
        run_op(1, 0, 3'd5, 4'd13, 1, 0, 1, 8'hF0);   // R5 short form: frame 128, fields ignored
        run_op(0, 0, 3'd3, 4'd7,  1, 1, 0, 8'h05);   // R5 short form restore, frame 40
        run_op(1, 1, 3'd0, 4'd15, 1, 1, 1, 8'd8);    // R8 reserved code
        run_op(1, 0, 3'd0, 4'd15, 0, 0, 0, 8'd1);    // R8 short form ignores code 15
        run_op(1, 1, 3'd0, 4'd0,  0, 0, 0, 8'd255);  // R6 frame only, largest frame
        run_op(0, 1, 3'd0, 4'd0,  0, 0, 0, 8'd255);
        for (int n = 0; n < 40; n++) begin
            regs[29] = 32'h400 + ({$urandom} % 256) * 4;
            run_op($urandom % 2, $urandom % 2, 3'($urandom), 4'($urandom),
                   $urandom % 2, $urandom % 2, $urandom % 2, 8'($urandom));
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule